// File: doc/BRIEF.md
# FFT Stage Address Generator

This block drives the memory side of a radix-2 butterfly engine for one stage of an in-place style FFT that ping-pongs between two working buffers. A controller pulses a start input together with the stage span S, given as log2(S). The block then walks a step counter i through every butterfly of the stage. For each step it presents, on one cycle, the two addresses to read from the previous stage's buffer, the two addresses to write in the next stage's buffer, and the twiddle-table address.

The counter value is split into a low field j, made of the lowest log2(S) bits, and a high field kS, made of the bits above them. Every address is formed from these two fields. The high field is shifted up by one bit, a low field is either kept or cleared, the top bit is set, and one add of S is made. No multiplier and no bit-reversal is used. A valid flag marks the steps, and a one-cycle done pulse follows the last step. The memories, the butterfly arithmetic and the twiddle storage sit outside this block.

Top module: `stage_addr_gen`

## Requirements
- R1: While reset is asserted and after it is released, valid_o and done_o are 0 and all five address outputs are 0 until the first start is accepted.
- R2: A start_i sampled high while idle is accepted at that clock edge. valid_o rises after the next edge and stays high for exactly N/2 consecutive cycles.
- R3: During the valid cycles, wr_a_o carries the step index i, counting 0, 1, ..., N/2-1, one value per cycle.
- R4: On each valid cycle, wr_b_o equals i + N/2, which is i with address bit log2(N)-1 set.
- R5: On each valid cycle, rd_a_o equals 2*(i - (i mod S)) + (i mod S). This is the high field shifted left one bit, with the low log2(S) bits kept.
- R6: On each valid cycle, rd_b_o equals rd_a_o + S.
- R7: On each valid cycle, tw_o equals 2*(i - (i mod S)). This is rd_a_o with its low log2(S) bits forced to 0.
- R8: done_o is high for exactly one cycle, the cycle right after the last valid cycle, when valid_o is already 0.
- R9: A start_i pulse while a stage is running is ignored. The running sequence continues unchanged and no extra valid cycles follow the done pulse.
- R10: The span is captured when start is accepted. Changes on span_log2_i during a stage do not alter the addresses of that stage.
- R11: Between stages, the address outputs hold the values of the last step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a stage when idle |
| span_log2_i | input | $clog2($clog2(N)) | log2 of span S, must be below log2(N) |
| rd_a_o | output | log2(N) | First read address, 2kS+j |
| rd_b_o | output | log2(N) | Second read address, 2kS+S+j |
| wr_a_o | output | log2(N) | First write address, kS+j |
| wr_b_o | output | log2(N) | Second write address, kS+j+N/2 |
| tw_o | output | log2(N) | Twiddle address, 2kS |
| valid_o | output | 1 | Addresses valid for this step |
| done_o | output | 1 | One-cycle pulse after the last step |

## Verification
The assertions take two things for granted about the inputs. First, span_log2_i is below log2(N) whenever a start is accepted. Second, the controller is content to have starts dropped while a stage runs. The bench only ever drives legal spans, and it sweeps every legal span, so the wrap-free address range holds on every step. It does pulse start and change the span in the middle of stages, on purpose, to show that both are ignored.

// File: rtl/stage_agen_pkg.sv
package stage_agen_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } agen_state_e;
endpackage

// File: rtl/stage_agen_ctr.sv
module stage_agen_ctr
  import stage_agen_pkg::*;
#(
  parameter int AW = 4,
  parameter int SW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] span_i,
  output logic          run_o,
  output logic          last_o,
  output logic [AW-1:0] idx_o,
  output logic [SW-1:0] span_o
);
  localparam logic [AW-1:0] LAST_IDX = {1'b0, {(AW-1){1'b1}}};

  agen_state_e   st_q;
  logic [AW-1:0] idx_q;
  logic [SW-1:0] span_q;
  logic          last;

  assign last = (st_q == ST_RUN) && (idx_q == LAST_IDX);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      span_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q   <= ST_RUN;
          idx_q  <= '0;
          span_q <= span_i;
        end
        ST_RUN: begin
          if (last) st_q <= ST_IDLE;
          else      idx_q <= idx_q + AW'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o  = (st_q == ST_RUN);
  assign last_o = last;
  assign idx_o  = idx_q;
  assign span_o = span_q;

  // input contract: span must address inside the buffer
  p_span_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && st_q == ST_IDLE) |-> (int'(span_i) < AW));

  // running stage ignores start and keeps counting
  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !last && start_i) |=> (run_o && idx_o == $past(idx_o) + AW'(1)));

  // span held for the whole stage
  p_span_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && $past(run_o)) |-> $stable(span_o));
endmodule

// File: rtl/stage_agen_addr.sv
module stage_agen_addr #(
  parameter int AW = 4,
  parameter int SW = 2
) (
  input  logic [AW-1:0] idx_i,
  input  logic [SW-1:0] span_i,
  output logic [AW-1:0] rd_a_o,
  output logic [AW-1:0] rd_b_o,
  output logic [AW-1:0] wr_a_o,
  output logic [AW-1:0] wr_b_o,
  output logic [AW-1:0] tw_o
);
  localparam logic [AW-1:0] TOP_BIT = {1'b1, {(AW-1){1'b0}}};

  logic [AW-1:0] lo_mask;
  logic [AW-1:0] j_fld;
  logic [AW-1:0] hi_fld;
  logic [AW-1:0] hi_dbl;
  logic [AW-1:0] stride;

  // lo_mask[b] set for the log2(S) lowest bits
  for (genvar b = 0; b < AW; b++) begin : g_mask
    assign lo_mask[b] = (int'(span_i) > b);
  end

  assign j_fld  = idx_i & lo_mask;
  assign hi_fld = idx_i & ~lo_mask;
  assign hi_dbl = hi_fld << 1;
  assign stride = AW'(1) << span_i;

  always_comb begin
    rd_a_o = hi_dbl | j_fld;
    rd_b_o = rd_a_o + stride;
    wr_a_o = idx_i;
    wr_b_o = idx_i | TOP_BIT;
    tw_o   = hi_dbl;
  end
endmodule

// File: rtl/stage_agen_oreg.sv
module stage_agen_oreg #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          last_i,
  input  logic [AW-1:0] rd_a_i,
  input  logic [AW-1:0] rd_b_i,
  input  logic [AW-1:0] wr_a_i,
  input  logic [AW-1:0] wr_b_i,
  input  logic [AW-1:0] tw_i,
  output logic [AW-1:0] rd_a_o,
  output logic [AW-1:0] rd_b_o,
  output logic [AW-1:0] wr_a_o,
  output logic [AW-1:0] wr_b_o,
  output logic [AW-1:0] tw_o,
  output logic          valid_o,
  output logic          done_o
);
  localparam logic [AW-1:0] TOP_BIT  = {1'b1, {(AW-1){1'b0}}};
  localparam logic [AW-1:0] LAST_IDX = {1'b0, {(AW-1){1'b1}}};

  logic last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_a_o  <= '0;
      rd_b_o  <= '0;
      wr_a_o  <= '0;
      wr_b_o  <= '0;
      tw_o    <= '0;
      valid_o <= 1'b0;
      last_q  <= 1'b0;
      done_o  <= 1'b0;
    end else begin
      valid_o <= run_i;
      last_q  <= last_i;
      done_o  <= last_q;
      // hold last step's addresses while idle
      if (run_i) begin
        rd_a_o <= rd_a_i;
        rd_b_o <= rd_b_i;
        wr_a_o <= wr_a_i;
        wr_b_o <= wr_b_i;
        tw_o   <= tw_i;
      end
    end
  end

  p_first_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !$past(valid_o)) |-> (wr_a_o == '0));

  p_step_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && $past(valid_o)) |-> (wr_a_o == $past(wr_a_o) + AW'(1)));

  p_run_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(valid_o) |-> ($past(wr_a_o) == LAST_IDX));

  p_wr_hi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (wr_b_o == (wr_a_o + TOP_BIT)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(valid_o) && !valid_o && !$past(done_o)));

  p_hold_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!valid_o && !$past(valid_o)) |-> ($stable(rd_a_o) && $stable(tw_o)));
endmodule

// File: rtl/stage_addr_gen.sv
module stage_addr_gen #(
  parameter int N  = 16,
  parameter int AW = $clog2(N),
  parameter int SW = $clog2(AW)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [SW-1:0] span_log2_i,
  output logic [AW-1:0] rd_a_o,
  output logic [AW-1:0] rd_b_o,
  output logic [AW-1:0] wr_a_o,
  output logic [AW-1:0] wr_b_o,
  output logic [AW-1:0] tw_o,
  output logic          valid_o,
  output logic          done_o
);
  logic          run;
  logic          last;
  logic [AW-1:0] idx;
  logic [SW-1:0] span_q;
  logic [AW-1:0] c_rd_a, c_rd_b, c_wr_a, c_wr_b, c_tw;

  stage_agen_ctr #(.AW(AW), .SW(SW)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .span_i  (span_log2_i),
    .run_o   (run),
    .last_o  (last),
    .idx_o   (idx),
    .span_o  (span_q)
  );

  stage_agen_addr #(.AW(AW), .SW(SW)) u_addr (
    .idx_i  (idx),
    .span_i (span_q),
    .rd_a_o (c_rd_a),
    .rd_b_o (c_rd_b),
    .wr_a_o (c_wr_a),
    .wr_b_o (c_wr_b),
    .tw_o   (c_tw)
  );

  stage_agen_oreg #(.AW(AW)) u_oreg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .last_i  (last),
    .rd_a_i  (c_rd_a),
    .rd_b_i  (c_rd_b),
    .wr_a_i  (c_wr_a),
    .wr_b_i  (c_wr_b),
    .tw_i    (c_tw),
    .rd_a_o  (rd_a_o),
    .rd_b_o  (rd_b_o),
    .wr_a_o  (wr_a_o),
    .wr_b_o  (wr_b_o),
    .tw_o    (tw_o),
    .valid_o (valid_o),
    .done_o  (done_o)
  );

  // span register stays fixed from accept until after the last valid step
  logic [AW-1:0] s_chk;
  assign s_chk = AW'(1) << span_q;

  p_rd_b_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (rd_b_o == rd_a_o + s_chk));

  p_tw_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((rd_a_o >= tw_o) && ((rd_a_o - tw_o) < s_chk)));

  p_rd_a_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((rd_a_o - tw_o) == (wr_a_o % s_chk)));
endmodule

// File: tb/stage_addr_gen_tb.sv
module stage_addr_gen_tb;
  localparam int N  = 16;
  localparam int AW = $clog2(N);
  localparam int SW = $clog2(AW);

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [SW-1:0] span_log2_i = '0;
  logic [AW-1:0] rd_a_o, rd_b_o, wr_a_o, wr_b_o, tw_o;
  logic          valid_o, done_o;

  int checks = 0;
  int failures = 0;
  bit timed_out = 0;

  always #2.5 clk = ~clk;

  stage_addr_gen #(.N(N)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .span_log2_i (span_log2_i),
    .rd_a_o      (rd_a_o),
    .rd_b_o      (rd_b_o),
    .wr_a_o      (wr_a_o),
    .wr_b_o      (wr_b_o),
    .tw_o        (tw_o),
    .valid_o     (valid_o),
    .done_o      (done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid in reset", int'(valid_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(valid_o == 1'b0, "R1 valid after reset", int'(valid_o), 0);
    chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    chk(rd_a_o == 0 && rd_b_o == 0 && wr_a_o == 0 && wr_b_o == 0 && tw_o == 0,
        "R1 addresses after reset", int'(rd_b_o), 0);
  endtask

  // mode 0: clean, 1: start pulse mid-stage, 2: span change mid-stage
  task automatic t_stage(input int s, input int mode);
    int sv = 1 << s;
    int other = (s + 1) % AW;
    int lo, hi;
    @(negedge clk);
    start_i = 1'b1;
    span_log2_i = SW'(s);
    @(negedge clk);
    start_i = 1'b0;
    chk(valid_o == 1'b0, "R2 no valid on accept cycle", int'(valid_o), 0);
    for (int k = 0; k < N / 2; k++) begin
      @(negedge clk);
      if (k == 4 && mode != 0) start_i = 1'b0;
      lo = k % sv;
      hi = k - lo;
      chk(valid_o == 1'b1, "R2 valid during stage", int'(valid_o), 1);
      chk(done_o == 1'b0, "R8 no done during stage", int'(done_o), 0);
      chk(int'(wr_a_o) == k, (mode == 1) ? "R9 wr_a under start" : "R3 wr_a", int'(wr_a_o), k);
      chk(int'(wr_b_o) == k + N / 2, "R4 wr_b", int'(wr_b_o), k + N / 2);
      chk(int'(rd_a_o) == 2 * hi + lo, (mode == 2) ? "R10 rd_a under span change" : "R5 rd_a",
          int'(rd_a_o), 2 * hi + lo);
      chk(int'(rd_b_o) == 2 * hi + lo + sv, (mode == 2) ? "R10 rd_b under span change" : "R6 rd_b",
          int'(rd_b_o), 2 * hi + lo + sv);
      chk(int'(tw_o) == 2 * hi, "R7 tw", int'(tw_o), 2 * hi);
      if (k == 3 && mode == 1) begin
        start_i = 1'b1;
        span_log2_i = SW'(other);
      end
      if (k == 3 && mode == 2) span_log2_i = SW'(other);
    end
    @(negedge clk);
    chk(valid_o == 1'b0, "R2 valid ends after N/2", int'(valid_o), 0);
    chk(done_o == 1'b1, "R8 done after last step", int'(done_o), 1);
    @(negedge clk);
    chk(done_o == 1'b0, "R8 done one cycle", int'(done_o), 0);
    chk(valid_o == 1'b0, (mode == 1) ? "R9 no restart" : "R2 stays idle", int'(valid_o), 0);
    lo = (N / 2 - 1) % sv;
    hi = (N / 2 - 1) - lo;
    repeat (2) @(negedge clk);
    chk(int'(rd_a_o) == 2 * hi + lo && int'(wr_a_o) == N / 2 - 1, "R11 hold when idle",
        int'(rd_a_o), 2 * hi + lo);
  endtask

  initial begin
    fork
      begin
        t_reset();
        for (int s = 0; s < AW; s++) t_stage(s, 0);
        t_stage(1, 1);
        t_stage(2, 2);
        t_stage(0, 1);
        t_stage(AW - 1, 2);
      end
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule